// File: doc/BRIEF.md
# Oscillator Run and Startup Sequencer

This block decides when an external oscillator should be powered and when its output can be trusted. A master enable and an on-demand mode select set the run condition. When on-demand is off, an enabled oscillator runs all the time. When on-demand is on, it runs only while at least one peripheral asserts a clock request.

Each time the oscillator is started, the block waits a programmable number of slow-clock periods before it reports the clock as usable. The wait is two raised to a 4-bit code, so it ranges from 1 to 32768 periods. The slow clock of about 32 kHz arrives as a plain input. The block synchronizes it into the system clock domain and counts its rising edges. A standby indication is accepted but does not change the gating: on-demand behaviour is the same in standby as when awake.

Top module: `osc_ondemand_ctl`

## Requirements
- R1: With enable=1 and ondemand=0, osc_run is 1 whatever the value of periph_req.
- R2: With enable=1 and ondemand=1, osc_run is 1 when any bit of periph_req is 1, and 0 when periph_req is all zeros.
- R3: The standby input has no effect. In standby the on-demand gating of R2 and the always-on behaviour of R1 apply unchanged.
- R4: With enable=0, osc_run and clk_ready are 0 whatever the other inputs are.
- R5: After osc_run rises, clk_ready rises at the system-clock edge that registers the 2^code-th synchronized rising edge of slow_clk. Here code is startup_code read as an unsigned number, so 0x0 gives 1 edge and 0xD gives 8192 edges. clk_ready is 0 in the cycle osc_run rises.
- R6: startup_code is captured when a start begins. Changes to it during the startup wait do not change that wait.
- R7: When the run condition becomes false, osc_run and clk_ready are both 0 after the next system-clock edge.
- R8: The startup edge count restarts from zero on every new start. An interrupted start leaves no credit toward the next one.
- R9: A peripheral request that arrives while a start is in progress does not shorten the startup wait.
- R10: start_done is a single-cycle pulse that is high exactly in the first cycle in which clk_ready is 1.
- R11: While rst_n is low, and right after reset with enable=0, osc_run, clk_ready and start_done are 0.
- R12: clk_ready is 1 only while osc_run is 1. Once high, it stays high for as long as the run condition holds.
- R13: While the oscillator is off, osc_run rises at the first system-clock edge at which the run condition is true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_clk | input | 1 | Slow reference clock (about 32 kHz), sampled as data |
| enable | input | 1 | Master oscillator enable |
| ondemand | input | 1 | 1: run only while requested; 0: run whenever enabled |
| standby | input | 1 | Standby sleep indication |
| startup_code | input | 4 | Startup wait selector, 2^code slow-clock edges |
| periph_req | input | NREQ | Clock requests from peripherals, one bit each |
| osc_run | output | 1 | Oscillator power/run command |
| clk_ready | output | 1 | Oscillator clock usable |
| start_done | output | 1 | One-cycle pulse when the startup wait completes |

## Verification
The bench measures the time from osc_run rising to clk_ready rising. It checks that this time falls in the window for exactly 2^code slow edges, so a counter that ends one edge early or late is caught. It interrupts a start partway and then restarts, which catches a counter that keeps its count across an off period and so becomes ready too soon. It changes startup_code during a wait, which catches a design that compares against the live input. It also raises a second request during a wait, which catches a design that resets or skips ahead on request changes. Table vectors cover on-demand, standby and disable combinations. A design that lets standby override the gating would show the wrong osc_run value there.

// File: rtl/osc_ondemand_ctl.sv
module osc_ondemand_ctl #(
  parameter int NREQ   = 8,
  parameter int CODE_W = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              enable,
  input  logic              ondemand,
  input  logic              standby,
  input  logic [CODE_W-1:0] startup_code,
  input  logic [NREQ-1:0]   periph_req,
  output logic              osc_run,
  output logic              clk_ready,
  output logic              start_done
);
  localparam int CNT_W = 1 << CODE_W;

  typedef enum logic [1:0] {S_OFF, S_START, S_READY} st_t;

  st_t               st;
  logic [SYNC_N:0]   sync_q;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic              gate, run_c, tick, last;
  logic [CNT_W:0]    target;

  always_comb begin
    case ({standby, ondemand})
      2'b00:   gate = 1'b1;
      2'b10:   gate = 1'b1;
      2'b01:   gate = |periph_req;
      default: gate = |periph_req;
    endcase
  end

  assign run_c  = enable & gate;
  assign tick   = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
  assign target = (CNT_W+1)'(1) << code_q;
  assign last   = (({1'b0, cnt_q}) + (CNT_W+1)'(1)) == target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-1:0], slow_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_OFF;
      cnt_q  <= '0;
      code_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!run_c) begin
        st    <= S_OFF;
        cnt_q <= '0;
      end else begin
        case (st)
          S_OFF: begin
            st     <= S_START;
            cnt_q  <= '0;
            code_q <= startup_code;
          end
          S_START: begin
            if (tick) begin
              if (last) begin
                st     <= S_READY;
                done_q <= 1'b1;
              end else begin
                cnt_q <= cnt_q + CNT_W'(1);
              end
            end
          end
          S_READY: st <= S_READY;
          default: st <= S_OFF;
        endcase
      end
    end
  end

  assign osc_run    = (st != S_OFF);
  assign clk_ready  = (st == S_READY);
  assign start_done = done_q;
endmodule

// File: rtl/osc_ondemand_ctl_chk.sv
module osc_ondemand_ctl_chk #(
  parameter int NREQ = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            ondemand,
  input logic [NREQ-1:0] periph_req,
  input logic            osc_run,
  input logic            clk_ready,
  input logic            start_done
);
  logic want;
  assign want = enable & (~ondemand | (|periph_req));

  assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !want |=> (!osc_run && !clk_ready));

  assert_wake_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_run && want) |=> osc_run);

  assert_keep_run_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_run && want) |=> osc_run);

  assert_ready_in_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clk_ready |-> osc_run);

  assert_ready_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_ready && want) |=> clk_ready);

  assert_start_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_run) |-> !clk_ready);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_done |=> !start_done);

  assert_done_at_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_done |-> (clk_ready && !$past(clk_ready)));

  assert_edge_has_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_ready) |-> start_done);
endmodule

bind osc_ondemand_ctl osc_ondemand_ctl_chk #(.NREQ(NREQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .ondemand(ondemand),
  .periph_req(periph_req), .osc_run(osc_run), .clk_ready(clk_ready),
  .start_done(start_done)
);

// File: tb/osc_ondemand_ctl_tb.sv
module osc_ondemand_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_clk = 1'b0;
  logic       enable = 1'b0;
  logic       ondemand = 1'b0;
  logic       standby = 1'b0;
  logic [3:0] startup_code = 4'h0;
  logic [7:0] periph_req = 8'h00;
  logic       osc_run, clk_ready, start_done;

  int n_chk = 0;
  int n_bad = 0;

  osc_ondemand_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .enable(enable),
    .ondemand(ondemand), .standby(standby), .startup_code(startup_code),
    .periph_req(periph_req), .osc_run(osc_run), .clk_ready(clk_ready),
    .start_done(start_done)
  );

  always #2 clk = ~clk;
  initial begin
    #1;
    forever #8 slow_clk = ~slow_clk;
  end

  // {enable, ondemand, standby, req[7:0], expected run}
  localparam logic [11:0] VEC [10] = '{
    {3'b100, 8'h00, 1'b1},
    {3'b100, 8'hA5, 1'b1},
    {3'b101, 8'h00, 1'b1},
    {3'b110, 8'h00, 1'b0},
    {3'b110, 8'h01, 1'b1},
    {3'b110, 8'h80, 1'b1},
    {3'b111, 8'h00, 1'b0},
    {3'b111, 8'h10, 1'b1},
    {3'b000, 8'hFF, 1'b0},
    {3'b011, 8'hFF, 1'b0}
  };

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic chk_win(input string rq, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", rq, act, lo, hi);
    end
  endtask

  task automatic go_off();
    @(negedge clk);
    enable = 1'b0; ondemand = 1'b0; periph_req = 8'h00;
    repeat (3) @(negedge clk);
  endtask

  // starts from off, returns cycles from osc_run high to clk_ready high
  task automatic measure(input logic [3:0] code, input logic [3:0] code_after,
                         input logic od, input logic [7:0] req0,
                         input logic [7:0] req_late, input int late_at,
                         output int lat);
    @(negedge clk);
    startup_code = code; ondemand = od; periph_req = req0; enable = 1'b1;
    @(negedge clk);
    chk("R13 run rises", int'(osc_run), 1);
    chk("R5 not ready at start", int'(clk_ready), 0);
    startup_code = code_after;
    lat = 0;
    while (!clk_ready && lat < 140000) begin
      @(negedge clk);
      lat++;
      if (lat == late_at) periph_req = req0 | req_late;
    end
    chk("R10 done with ready rise", int'(start_done), 1);
    @(negedge clk);
    chk("R10 done one cycle", int'(start_done), 0);
    chk("R12 ready held", int'(clk_ready), 1);
  endtask

  initial begin
    int lat;
    int n;
    repeat (3) @(negedge clk);
    chk("R11 run in reset", int'(osc_run), 0);
    chk("R11 ready in reset", int'(clk_ready), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 run after reset", int'(osc_run), 0);
    chk("R11 ready after reset", int'(clk_ready), 0);
    chk("R11 done after reset", int'(start_done), 0);

    startup_code = 4'h0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      enable = VEC[i][11]; ondemand = VEC[i][10]; standby = VEC[i][9];
      periph_req = VEC[i][8:1];
      repeat (12) @(negedge clk);
      chk($sformatf("R1/R2/R3/R4 vec%0d run", i), int'(osc_run), int'(VEC[i][0]));
      chk($sformatf("R12 vec%0d ready", i), int'(clk_ready), int'(VEC[i][0]));
    end
    standby = 1'b0;
    go_off();

    foreach (VEC[k]) begin end
    for (int c = 0; c < 14; c++) begin
      if (c == 0 || c == 1 || c == 3 || c == 6 || c == 13) begin
        n = 1 << c;
        measure(c[3:0], c[3:0], 1'b0, 8'h00, 8'h00, 0, lat);
        chk_win($sformatf("R5 code %0d latency", c), lat, 4*n-3, 4*n);
        go_off();
      end
    end

    n = 1 << 2;
    measure(4'h2, 4'hF, 1'b0, 8'h00, 8'h00, 0, lat);
    chk_win("R6 code change ignored", lat, 4*n-3, 4*n);
    go_off();

    n = 1 << 4;
    measure(4'h4, 4'h4, 1'b1, 8'h01, 8'h08, 20, lat);
    chk_win("R9 late request", lat, 4*n-3, 4*n);
    @(negedge clk);
    periph_req = 8'h00;
    @(negedge clk);
    chk("R7 drop from ready run", int'(osc_run), 0);
    chk("R7 drop from ready ready", int'(clk_ready), 0);
    go_off();

    @(negedge clk);
    startup_code = 4'h4; enable = 1'b1;
    repeat (40) @(negedge clk);
    chk("R5 still starting", int'(clk_ready), 0);
    enable = 1'b0;
    @(negedge clk);
    chk("R7 drop while starting", int'(osc_run), 0);
    @(negedge clk);
    measure(4'h4, 4'h4, 1'b0, 8'h00, 8'h00, 0, lat);
    chk_win("R8 restart from zero", lat, 4*n-3, 4*n);
    go_off();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule